// File: doc/BRIEF.md
# Persistence Filter and Delay-Tap Selector

This block sits in the skew-correction loop of a serial data receiver. Once per parallel-word clock it takes two voted requests: one asks for more delay on the incoming stream and the other asks for less. A small state machine passes a request on only after it has persisted, so that isolated requests caused by jitter are dropped. Each accepted request gives a one-cycle strobe and moves a one-hot tap-select vector by one position. That vector chooses which of three delayed copies of the stream is sampled.

The direction counting is kept in a control module. The control hands single-cycle shift commands to a datapath module, which holds the one-hot select and stops at both ends. The number of consecutive periods needed and the number of taps are parameters, with defaults of three and three.

Top module: `dlf_tap_select`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `tapSel` is 3'b001 (bit 0 is the tap with the least delay) and both strobes are low. A reset in the middle of a count discards the partial count.
- R2: When `upReq`=1 and `dnReq`=0 are sampled on three consecutive rising edges, `upStrobe` is high for exactly the one cycle that follows the third edge.
- R3: When `dnReq`=1 and `upReq`=0 are sampled on three consecutive rising edges, `dnStrobe` is high for exactly the one cycle that follows the third edge.
- R4: A sampled cycle with no request, or with the opposite request, restarts the count for a direction. An opposite request counts as the first cycle of its own direction.
- R5: `upReq` and `dnReq` sampled high together count as no request, so that cycle gives no strobe and restarts the count.
- R6: After a strobe the filter starts counting from zero. A request held steadily therefore gives a strobe on every third cycle, and never on two adjacent cycles.
- R7: On the edge that follows a cycle with `upStrobe` high, the high bit of `tapSel` moves one place toward the MSB (more delay): 001 becomes 010, and 010 becomes 100.
- R8: On the edge that follows a cycle with `dnStrobe` high, the high bit moves one place toward bit 0 (less delay): 100 becomes 010, and 010 becomes 001.
- R9: The select saturates. An up strobe while `tapSel`=100 leaves the select unchanged, and so does a down strobe while `tapSel`=001.
- R10: `tapSel` has exactly one bit high on every cycle.
- R11: `upStrobe` and `dnStrobe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel-word clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReq | input | 1 | Voted request for one more phase of delay |
| dnReq | input | 1 | Voted request for one less phase of delay |
| upStrobe | output | 1 | Accepted up request, high for one cycle |
| dnStrobe | output | 1 | Accepted down request, high for one cycle |
| tapSel | output | 3 | One-hot delay-tap select; bit 0 is the least delay |

## Verification
The assertions check the following on every cycle:
- the select stays one-hot;
- the two strobes never coincide;
- a strobe never follows a cycle that lacked a clean request of its own direction;
- a strobe never repeats on the next cycle;
- the select moves exactly one place, or holds at the ends.

The full count of three consecutive periods cannot be seen by any of those properties. Only the bench's sequences show it: the restarts after a gap, after an opposite request and after a coincident request, the walk across all three taps in both directions, and the discarding of a partial count by reset.

// File: rtl/dlf_tap_pkg.sv
package dlf_tap_pkg;

  // Single-cycle shift commands from the filter to the tap shifter
  typedef struct packed {
    logic up;
    logic dn;
  } shiftCmd_t;

  // Direction whose persistence is currently being counted
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;

endpackage

// File: rtl/dlf_persist_filter.sv
module dlf_persist_filter
  import dlf_tap_pkg::*;
#(
  parameter int PERSIST_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      upReq,
  input  logic      dnReq,
  output shiftCmd_t cmd
);

  localparam int CNT_W = $clog2(PERSIST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERSIST_CYCLES - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  dir_e            dirQ, dirNxt;
  logic [CNT_W-1:0] cntQ, cntNxt;
  logic            fireUp, fireDn;
  logic            cleanUp, cleanDn;

  // Coincident requests cancel to "no request"
  assign cleanUp = upReq & ~dnReq;
  assign cleanDn = dnReq & ~upReq;

  always_comb begin
    dirNxt = DIR_IDLE;
    cntNxt = '0;
    fireUp = 1'b0;
    fireDn = 1'b0;
    if (cleanUp) begin
      if (dirQ == DIR_UP && cntQ == LAST_CNT) begin
        fireUp = 1'b1;
      end else if (dirQ == DIR_UP) begin
        dirNxt = DIR_UP;
        cntNxt = cntQ + ONE_CNT;
      end else begin
        dirNxt = DIR_UP;
        cntNxt = ONE_CNT;
      end
    end else if (cleanDn) begin
      if (dirQ == DIR_DN && cntQ == LAST_CNT) begin
        fireDn = 1'b1;
      end else if (dirQ == DIR_DN) begin
        dirNxt = DIR_DN;
        cntNxt = cntQ + ONE_CNT;
      end else begin
        dirNxt = DIR_DN;
        cntNxt = ONE_CNT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= DIR_IDLE;
      cntQ   <= '0;
      cmd.up <= 1'b0;
      cmd.dn <= 1'b0;
    end else begin
      dirQ   <= dirNxt;
      cntQ   <= cntNxt;
      cmd.up <= fireUp;
      cmd.dn <= fireDn;
    end
  end

  // R11
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.up && cmd.dn));

  // R6
  up_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.up |=> !cmd.up);

  // R6
  dn_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dn |=> !cmd.dn);

  // R4 R5
  up_needs_clean_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!upReq || dnReq) |=> !cmd.up);

  // R4 R5
  dn_needs_clean_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dnReq || upReq) |=> !cmd.dn);

endmodule

// File: rtl/dlf_tap_shifter.sv
module dlf_tap_shifter
  import dlf_tap_pkg::*;
#(
  parameter int NUM_TAPS = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  shiftCmd_t           cmd,
  output logic [NUM_TAPS-1:0] tapSel
);

  localparam logic [NUM_TAPS-1:0] RST_SEL = NUM_TAPS'(1);

  logic [NUM_TAPS-1:0] nxtSel;
  logic                doUp, doDn;

  // Saturate at either end of the tap range
  assign doUp = cmd.up & ~tapSel[NUM_TAPS-1];
  assign doDn = cmd.dn & ~tapSel[0];

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_bit
    logic fromBelow, fromAbove;
    if (g == 0) begin : g_lo
      assign fromBelow = 1'b0;
    end else begin : g_lo
      assign fromBelow = tapSel[g-1];
    end
    if (g == NUM_TAPS - 1) begin : g_hi
      assign fromAbove = 1'b0;
    end else begin : g_hi
      assign fromAbove = tapSel[g+1];
    end
    assign nxtSel[g] = doUp ? fromBelow : (doDn ? fromAbove : tapSel[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) tapSel <= RST_SEL;
    else       tapSel <= nxtSel;
  end

  // R10
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1);

  // R7
  shift_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.up && !tapSel[NUM_TAPS-1]) |=> tapSel == ($past(tapSel) << 1));

  // R8
  shift_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.dn && !tapSel[0]) |=> tapSel == ($past(tapSel) >> 1));

  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd.up && tapSel[NUM_TAPS-1]) || (cmd.dn && tapSel[0])) |=> $stable(tapSel));

  // R7 R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.up && !cmd.dn) |=> $stable(tapSel));

endmodule

// File: rtl/dlf_tap_select.sv
module dlf_tap_select
  import dlf_tap_pkg::*;
#(
  parameter int PERSIST_CYCLES = 3,
  parameter int NUM_TAPS       = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                upReq,
  input  logic                dnReq,
  output logic                upStrobe,
  output logic                dnStrobe,
  output logic [NUM_TAPS-1:0] tapSel
);

  shiftCmd_t shiftCmd;

  dlf_persist_filter #(.PERSIST_CYCLES(PERSIST_CYCLES)) i_filter (
    .clk   (clk),
    .rstN  (rstN),
    .upReq (upReq),
    .dnReq (dnReq),
    .cmd   (shiftCmd)
  );

  dlf_tap_shifter #(.NUM_TAPS(NUM_TAPS)) i_shifter (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (shiftCmd),
    .tapSel (tapSel)
  );

  assign upStrobe = shiftCmd.up;
  assign dnStrobe = shiftCmd.dn;

endmodule

// File: tb/test_dlf_tap_select.sv
module test_dlf_tap_select;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upReq = 1'b0;
  logic       dnReq = 1'b0;
  logic       upStrobe, dnStrobe;
  logic [2:0] tapSel;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dlf_tap_select i_dlf_tap_select (
    .clk      (clk),
    .rstN     (rstN),
    .upReq    (upReq),
    .dnReq    (dnReq),
    .upStrobe (upStrobe),
    .dnStrobe (dnStrobe),
    .tapSel   (tapSel)
  );

  // Row = {upReq, dnReq, expUpStrobe, expDnStrobe, expTapSel[2:0]}
  localparam int NROWS = 31;
  localparam logic [6:0] VEC [NROWS] = '{
    7'b10_00_001, 7'b10_00_001, 7'b10_10_001,
    7'b10_00_010, 7'b10_00_010, 7'b10_10_010,
    7'b10_00_100, 7'b10_00_100, 7'b10_10_100,
    7'b00_00_100,
    7'b10_00_100, 7'b00_00_100,
    7'b10_00_100, 7'b10_00_100, 7'b01_00_100, 7'b01_00_100,
    7'b11_00_100,
    7'b01_00_100, 7'b01_00_100, 7'b01_01_100,
    7'b00_00_010,
    7'b01_00_010, 7'b01_00_010, 7'b01_01_010,
    7'b01_00_001, 7'b01_00_001, 7'b01_01_001,
    7'b00_00_001,
    7'b11_00_001, 7'b11_00_001, 7'b11_00_001
  };

  function automatic string rowTag(int i);
    if (i <= 8)  return "R2 R6 R7";
    if (i == 9)  return "R9";
    if (i <= 15) return "R4";
    if (i == 16) return "R5";
    if (i <= 26) return "R3 R6 R8";
    if (i == 27) return "R9";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [2:0] expSel, logic expUp, logic expDn);
    testCnt++;
    if (tapSel !== expSel || upStrobe !== expUp || dnStrobe !== expDn) begin
      failCnt++;
      $display("FAIL %s: sel=%b up=%b dn=%b expected sel=%b up=%b dn=%b",
               tag, tapSel, upStrobe, dnStrobe, expSel, expUp, expDn);
    end
  endtask

  task automatic chkInvariants(string tag);
    testCnt++;
    if ($countones(tapSel) != 1 || (upStrobe && dnStrobe)) begin
      failCnt++;
      $display("FAIL %s: sel=%b up=%b dn=%b expected one-hot sel, exclusive strobes",
               tag, tapSel, upStrobe, dnStrobe);
    end
  endtask

  task automatic step(logic u, logic d);
    @(negedge clk);
    upReq = u;
    dnReq = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", 3'b001, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 after release", 3'b001, 1'b0, 1'b0);

    // Vector table
    for (int i = 0; i < NROWS; i++) begin
      step(VEC[i][6], VEC[i][5]);
      chk(rowTag(i), VEC[i][2:0], VEC[i][4], VEC[i][3]);
      chkInvariants("R10 R11");
    end

    // R1: a reset in the middle of a count discards it
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 mid-count reset", 3'b001, 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    upReq = 1'b1;
    dnReq = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 count restarted 1", 3'b001, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R1 count restarted 2", 3'b001, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    chk("R2 strobe after reset", 3'b001, 1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R7 shift after reset", 3'b010, 1'b0, 1'b0);

    // R4: a gap between the second and third request
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk("R4 gap restarts down count", 3'b010, 1'b0, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule